// File: doc/BRIEF.md
# Linked Transfer-Descriptor Chain Walker

This block drives a serial flash or peripheral shifter from a list of transfer descriptors kept in system memory. Software builds a chain of four-word descriptors, puts the address of the first one on the base-address input and writes the engine control word with the enable and start bits. The walker then reads each descriptor over a simple word-read port and checks that hardware owns it. It decodes the length, direction, lane count, bit order and device select, and presents one command to the downstream shifter. It holds that command until the shifter reports completion.

When a descriptor has been shifted, the walker writes its control value back into the descriptor's status word with the ownership bit cleared. It then raises the per-descriptor and end-of-packet events that the descriptor asks for and, if asked, releases chip select. It follows the next pointer until a descriptor carries the end-of-list flag or a zero next pointer. Faults stop the walk, raise an error event and release chip select. The faults are a descriptor that software still owns, an oversized length, and an error response on a read. With polling enabled, an unowned descriptor is read again until software hands it over.

Top module: `bdchain_walker`

## Requirements
- R1: After reset the walker is idle: busy, rd_req, wr_req, cmd_valid and all four event outputs are 0 and cur_addr is 0.
- R2: An engine write with bits 0 (enable) and 2 (start) set while idle loads cur_addr from base_addr. The walker then reads the control word at cur_addr+0, the buffer address at cur_addr+8 and the next pointer at cur_addr+12, in that order. A start write with bit 0 clear does nothing.
- R3: The command carries length = control[8:0], rx = control[20], lsb-first = control[25], device = control[29:28] and the buffer address word. Lanes are encoded 0 single, 1 dual (control[22]) and 2 quad (control[23]), and quad wins when both bits are set.
- R4: cmd_valid and its fields stay stable until xfer_done. Then one write puts {0, control[30:0]} at cur_addr+4.
- R5: One cycle after that write is acknowledged, ev_bd_done pulses if control[16] is set, ev_pkt_done pulses if control[17] and control[18] are both set, and cs_release pulses if control[30] is set.
- R6: After a descriptor the walker moves cur_addr to the next pointer and continues. It goes idle instead when control[19] is set or the next pointer is 0.
- R7: A control word with bit 31 clear while polling (engine bit 1) is off raises ev_dma_err and cs_release, returns to idle and issues no command.
- R8: With polling on, an unowned control word is read again until bit 31 is found set, and the walk then continues normally.
- R9: A length above 256 is a fault handled as in R7. A length of exactly 256 is accepted.
- R10: A read acknowledged with rd_err set on any descriptor word raises ev_dma_err and cs_release and returns to idle.
- R11: An engine write with bit 0 clear stops the walker in the next cycle from any state, with no done, packet or write-back activity.
- R12: rd_addr stays stable while rd_req waits for rd_ack. rd_req, wr_req and cmd_valid are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_wr | input | 1 | Engine control write strobe |
| eng_wdata | input | 3 | Bit 0 enable, bit 1 polling, bit 2 start |
| base_addr | input | AW | Address of first descriptor |
| rd_req | output | 1 | Word read request, held until rd_ack |
| rd_addr | output | AW | Byte address of the word to read |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 32 | Read data, valid with rd_ack |
| rd_err | input | 1 | Error response, valid with rd_ack |
| wr_req | output | 1 | Status write request, held until wr_ack |
| wr_addr | output | AW | Status word address |
| wr_data | output | 32 | Status value written back |
| wr_ack | input | 1 | Write acknowledge |
| cmd_valid | output | 1 | Command to shifter valid |
| cmd_len | output | 9 | Byte count |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_rx | output | 1 | 1 receive, 0 transmit |
| cmd_lsb | output | 1 | LSB-first bit order |
| cmd_dev | output | 2 | Device select |
| cmd_buf | output | AW | Data buffer address |
| xfer_done | input | 1 | Shifter finished the command |
| ev_bd_done | output | 1 | Per-descriptor done pulse |
| ev_pkt_done | output | 1 | Packet complete pulse |
| ev_dma_err | output | 1 | Fault pulse |
| cs_release | output | 1 | Chip-select release pulse |
| busy | output | 1 | Walker not idle |
| cur_addr | output | AW | Descriptor being processed |

## Verification
The assertions check on every cycle that read addresses and commands stay stable while waiting, that the three request outputs never overlap, that a fault leaves the walker idle with chip select released, that a stop write idles it at once, and that no command exceeds the length limit. Decoding of every combination of lane, direction, order, device and event bits, the write-back value, the read order and the chain traversal by pointer and by end flag can only be shown by the bench's scenarios against its memory and shifter models. The same holds for the fault cases and for polling until ownership is handed over.

// File: rtl/bdchain_pkg.sv
package bdchain_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LEN_W   = 9;

    // control word bit positions (decoded by software and hardware alike)
    localparam int unsigned B_BD_IE  = 16;
    localparam int unsigned B_PKT_IE = 17;
    localparam int unsigned B_LIFM   = 18;
    localparam int unsigned B_END    = 19;
    localparam int unsigned B_RX     = 20;
    localparam int unsigned B_X2     = 22;
    localparam int unsigned B_X4     = 23;
    localparam int unsigned B_LSB    = 25;
    localparam int unsigned B_DEV_LO = 28;
    localparam int unsigned B_CSREL  = 30;
    localparam int unsigned B_OWN    = 31;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_CTRL, ST_RD_BUF, ST_RD_NEXT, ST_XFER, ST_WB
    } walk_state_t;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2
    } lane_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             rx;
        lane_t            lanes;
        logic             lsb;
        logic [1:0]       dev;
    } xfer_cmd_t;

    typedef struct packed {
        logic owned;
        logic len_bad;
        logic chain_end;
        logic bd_ie;
        logic pkt_ev;
        logic cs_rel;
    } desc_flags_t;

    function automatic lane_t pick_lanes(input logic x2, input logic x4);
        if (x4)      return LANE_X4;
        else if (x2) return LANE_X2;
        else         return LANE_X1;
    endfunction

endpackage

// File: rtl/bdchain_decode.sv
module bdchain_decode
    import bdchain_pkg::*;
#(
    parameter int unsigned MAX_LEN = 256
) (
    input  logic [WORD_W-1:0] ctrl_word,
    output xfer_cmd_t         cmd,
    output desc_flags_t       flags
);
    logic unused_bits;
    assign unused_bits = ^{ctrl_word[15:LEN_W], ctrl_word[21], ctrl_word[24],
                           ctrl_word[27:26]};

    always_comb begin
        cmd.len   = ctrl_word[LEN_W-1:0];
        cmd.rx    = ctrl_word[B_RX];
        cmd.lanes = pick_lanes(ctrl_word[B_X2], ctrl_word[B_X4]);
        cmd.lsb   = ctrl_word[B_LSB];
        cmd.dev   = ctrl_word[B_DEV_LO+1:B_DEV_LO];

        flags.owned     = ctrl_word[B_OWN];
        flags.len_bad   = {{(WORD_W-LEN_W){1'b0}}, ctrl_word[LEN_W-1:0]} > WORD_W'(MAX_LEN);
        flags.chain_end = ctrl_word[B_END];
        flags.bd_ie     = ctrl_word[B_BD_IE];
        flags.pkt_ev    = ctrl_word[B_PKT_IE] & ctrl_word[B_LIFM];
        flags.cs_rel    = ctrl_word[B_CSREL];
    end
endmodule

// File: rtl/bdchain_events.sv
module bdchain_events
    import bdchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        desc_done,
    input  logic        fault,
    input  desc_flags_t flags,
    output logic        ev_bd_done,
    output logic        ev_pkt_done,
    output logic        ev_dma_err,
    output logic        cs_release
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_bd_done  <= 1'b0;
            ev_pkt_done <= 1'b0;
            ev_dma_err  <= 1'b0;
            cs_release  <= 1'b0;
        end else begin
            ev_bd_done  <= desc_done & flags.bd_ie;
            ev_pkt_done <= desc_done & flags.pkt_ev;
            ev_dma_err  <= fault;
            cs_release  <= fault | (desc_done & flags.cs_rel);
        end
    end

    // R10 / R7: every fault releases chip select
    a_r10_err_releases_cs: assert property (@(posedge clk) disable iff (rst)
        ev_dma_err |-> cs_release);

    // R5: a done pulse and a fault never share a cycle
    a_r5_done_not_err: assert property (@(posedge clk) disable iff (rst)
        ev_bd_done |-> !ev_dma_err);
endmodule

// File: rtl/bdchain_walker.sv
module bdchain_walker
    import bdchain_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter int unsigned MAX_LEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_wr,
    input  logic [2:0]        eng_wdata,
    input  logic [AW-1:0]     base_addr,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              cmd_valid,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [1:0]        cmd_lanes,
    output logic              cmd_rx,
    output logic              cmd_lsb,
    output logic [1:0]        cmd_dev,
    output logic [AW-1:0]     cmd_buf,
    input  logic              xfer_done,
    output logic              ev_bd_done,
    output logic              ev_pkt_done,
    output logic              ev_dma_err,
    output logic              cs_release,
    output logic              busy,
    output logic [AW-1:0]     cur_addr
);
    localparam logic [AW-1:0] OFS_STAT = AW'(4);
    localparam logic [AW-1:0] OFS_BUF  = AW'(8);
    localparam logic [AW-1:0] OFS_NEXT = AW'(12);

    walk_state_t       state;
    logic [AW-1:0]     cur_q, buf_q, next_q;
    logic [WORD_W-1:0] ctrl_q;
    logic              poll_q;

    xfer_cmd_t   live_cmd, held_cmd;
    desc_flags_t live_flags, held_flags;

    bdchain_decode #(.MAX_LEN(MAX_LEN)) u_dec_live (
        .ctrl_word(rd_data), .cmd(live_cmd), .flags(live_flags));
    bdchain_decode #(.MAX_LEN(MAX_LEN)) u_dec_held (
        .ctrl_word(ctrl_q), .cmd(held_cmd), .flags(held_flags));

    logic stop_req, start_req, fault, desc_done, ctrl_bad;

    assign stop_req  = eng_wr & ~eng_wdata[0];
    assign start_req = eng_wr & eng_wdata[0] & eng_wdata[2] & (state == ST_IDLE);
    assign ctrl_bad  = rd_err | (~live_flags.owned & ~poll_q)
                     | (live_flags.owned & live_flags.len_bad);
    assign fault     = ~stop_req & rd_ack &
                       (((state == ST_RD_CTRL) & ctrl_bad) |
                        (((state == ST_RD_BUF) | (state == ST_RD_NEXT)) & rd_err));
    assign desc_done = ~stop_req & (state == ST_WB) & wr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            buf_q  <= '0;
            next_q <= '0;
            ctrl_q <= '0;
            poll_q <= 1'b0;
        end else if (stop_req) begin
            state <= ST_IDLE;
        end else begin
            if (eng_wr) poll_q <= eng_wdata[1];
            unique case (state)
                ST_IDLE: if (start_req) begin
                    cur_q <= base_addr;
                    state <= ST_RD_CTRL;
                end
                ST_RD_CTRL: if (rd_ack) begin
                    if (fault) state <= ST_IDLE;
                    else if (live_flags.owned) begin
                        ctrl_q <= rd_data;
                        state  <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: if (rd_ack) begin
                    if (rd_err) state <= ST_IDLE;
                    else begin
                        buf_q <= rd_data[AW-1:0];
                        state <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: if (rd_ack) begin
                    if (rd_err) state <= ST_IDLE;
                    else begin
                        next_q <= rd_data[AW-1:0];
                        state  <= ST_XFER;
                    end
                end
                ST_XFER: if (xfer_done) state <= ST_WB;
                ST_WB: if (wr_ack) begin
                    if (held_flags.chain_end || next_q == '0) state <= ST_IDLE;
                    else begin
                        cur_q <= next_q;
                        state <= ST_RD_CTRL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req  = (state == ST_RD_CTRL) | (state == ST_RD_BUF) | (state == ST_RD_NEXT);
        unique case (state)
            ST_RD_BUF:  rd_addr = cur_q + OFS_BUF;
            ST_RD_NEXT: rd_addr = cur_q + OFS_NEXT;
            default:    rd_addr = cur_q;
        endcase
        wr_req  = (state == ST_WB);
        wr_addr = cur_q + OFS_STAT;
        wr_data = {1'b0, ctrl_q[WORD_W-2:0]};
    end

    assign cmd_valid = (state == ST_XFER);
    assign cmd_len   = held_cmd.len;
    assign cmd_lanes = held_cmd.lanes;
    assign cmd_rx    = held_cmd.rx;
    assign cmd_lsb   = held_cmd.lsb;
    assign cmd_dev   = held_cmd.dev;
    assign cmd_buf   = buf_q;
    assign busy      = (state != ST_IDLE);
    assign cur_addr  = cur_q;

    bdchain_events u_events (
        .clk(clk), .rst(rst), .desc_done(desc_done), .fault(fault),
        .flags(held_flags), .ev_bd_done(ev_bd_done), .ev_pkt_done(ev_pkt_done),
        .ev_dma_err(ev_dma_err), .cs_release(cs_release));

    // R12: a pending read keeps its address
    a_r12_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !eng_wr) |=> (rd_req && $stable(rd_addr)));

    // R12: requests never overlap
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_req, wr_req, cmd_valid}) <= 1);

    // R4: command held until the shifter finishes
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !xfer_done && !eng_wr) |=>
        (cmd_valid && $stable({cmd_len, cmd_lanes, cmd_rx, cmd_lsb, cmd_dev, cmd_buf})));

    // R3: lane code 3 never issued
    a_r3_lane_code: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_lanes != 2'b11));

    // R9: no oversized command reaches the shifter
    a_r9_len_limit: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ({{(WORD_W-LEN_W){1'b0}}, cmd_len} <= WORD_W'(MAX_LEN)));

    // R7: a fault leaves the walker idle
    a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
        ev_dma_err |-> !busy);

    // R11: stop write idles the walker with no completion events
    a_r11_stop: assert property (@(posedge clk) disable iff (rst)
        (eng_wr && !eng_wdata[0]) |=> (!busy && !ev_bd_done && !ev_pkt_done));
endmodule

// File: tb/bdchain_walker_test.sv
module bdchain_walker_test;
    localparam int CLK_T = 10;
    localparam int AW    = 32;

    logic clk = 0, rst = 1;
    logic eng_wr = 0;
    logic [2:0] eng_wdata = '0;
    logic [AW-1:0] base_addr = '0;
    logic rd_req, rd_ack = 0, rd_err = 0;
    logic [AW-1:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic wr_req, wr_ack = 0;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;
    logic cmd_valid, cmd_rx, cmd_lsb, xfer_done = 0;
    logic [8:0] cmd_len;
    logic [1:0] cmd_lanes, cmd_dev;
    logic [AW-1:0] cmd_buf;
    logic ev_bd_done, ev_pkt_done, ev_dma_err, cs_release, busy;
    logic [AW-1:0] cur_addr;

    bdchain_walker uut (.*);

    always #(CLK_T/2) clk = ~clk;

    int errors = 0, checks = 0;
    logic [31:0] mem [0:63];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] rd_log [0:7];
    logic [31:0] wb_log [0:7];
    logic [31:0] cur_log [0:7];
    int rd_cnt = 0, wb_cnt = 0, cmd_cnt = 0;
    int bd_cnt = 0, pkt_cnt = 0, er_cnt = 0, cs_cnt = 0;
    int xfer_lat = 3, xcnt = 0;
    logic [8:0] cap_len;
    logic [1:0] cap_lanes, cap_dev;
    logic cap_rx, cap_lsb;
    logic [31:0] cap_buf;

    // memory model
    always @(negedge clk) begin
        if (rd_ack) rd_ack = 0;
        else if (rd_req) begin
            rd_ack = 1;
            rd_data = mem[rd_addr[7:2]];
            rd_err = (rd_addr == err_addr);
            if (rd_cnt < 8) rd_log[rd_cnt] = rd_addr;
            rd_cnt++;
        end
        if (wr_ack) wr_ack = 0;
        else if (wr_req) begin
            wr_ack = 1;
            mem[wr_addr[7:2]] = wr_data;
            if (wb_cnt < 8) wb_log[wb_cnt] = wr_addr;
            wb_cnt++;
        end
    end

    // shifter model
    always @(negedge clk) begin
        xfer_done = 0;
        if (!cmd_valid) xcnt = 0;
        else begin
            if (xcnt == 0) begin
                cap_len = cmd_len; cap_lanes = cmd_lanes; cap_rx = cmd_rx;
                cap_lsb = cmd_lsb; cap_dev = cmd_dev; cap_buf = cmd_buf;
                if (cmd_cnt < 8) cur_log[cmd_cnt] = cur_addr;
                cmd_cnt++;
            end
            xcnt++;
            if (xcnt == xfer_lat) begin xfer_done = 1; xcnt = 0; end
        end
    end

    // event counters
    always @(negedge clk) begin
        if (ev_bd_done) bd_cnt++;
        if (ev_pkt_done) pkt_cnt++;
        if (ev_dma_err) er_cnt++;
        if (cs_release) cs_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_logs();
        rd_cnt = 0; wb_cnt = 0; cmd_cnt = 0;
        bd_cnt = 0; pkt_cnt = 0; er_cnt = 0; cs_cnt = 0;
    endtask

    task automatic eng_write(input logic [2:0] v);
        @(negedge clk); eng_wr = 1; eng_wdata = v;
        @(negedge clk); eng_wr = 0; eng_wdata = '0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        if (n >= 3000) chk(0, "timeout", 0, 1);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] c,
                            input logic [31:0] b, input logic [31:0] nx);
        mem[a[7:2]] = c; mem[a[7:2]+1] = 32'hDEAD_0000;
        mem[a[7:2]+2] = b; mem[a[7:2]+3] = nx;
    endtask

    initial begin
        #(CLK_T*150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({busy, rd_req, wr_req, cmd_valid, ev_bd_done, ev_pkt_done, ev_dma_err, cs_release} == 0
            && cur_addr == 0, "R1 reset idle",
            {busy, rd_req, wr_req, cmd_valid, ev_bd_done, ev_pkt_done, ev_dma_err, cs_release}, 0);

        // R2 start without enable bit
        put_desc(32'h10, 32'h8008_0004, 32'h100, 0);
        base_addr = 32'h10; clr_logs();
        eng_write(3'b100);
        repeat (5) @(negedge clk);
        chk(!busy && rd_cnt == 0, "R2 start ignored without enable", {busy, 32'(rd_cnt)}, 0);

        // sweep of decode / events
        for (int i = 0; i < 256; i++) begin
            logic [31:0] c, b, a, nx;
            logic lifm, csr;
            logic [1:0] el;
            lifm = i[2] ^ i[5];
            csr  = i[1] ^ i[6];
            c = 32'h8008_0000 | 32'(i) | (32'(i[0]) << 22) | (32'(i[1]) << 23)
              | (32'(i[2]) << 20) | (32'(i[3]) << 25) | (32'(i[5:4]) << 28)
              | (32'(i[6]) << 16) | (32'(i[7]) << 17) | (32'(lifm) << 18) | (32'(csr) << 30);
            a  = 32'(16 * (1 + (i % 14)));
            b  = 32'h1000_0000 + 32'(i * 256);
            nx = i[0] ? 32'h10 : 32'h0;
            put_desc(a, c, b, nx);
            base_addr = a; clr_logs();
            eng_write(3'b101);
            wait_idle();
            el = i[1] ? 2'd2 : (i[0] ? 2'd1 : 2'd0);
            chk({cap_buf, 8'(cmd_cnt), cap_len, cap_lanes, cap_rx, cap_lsb, cap_dev} ==
                {b, 8'd1, 9'(i), el, i[2], i[3], i[5:4]}, "R3 command decode",
                {cap_buf, 8'(cmd_cnt), cap_len, cap_lanes, cap_rx, cap_lsb, cap_dev},
                {b, 8'd1, 9'(i), el, i[2], i[3], i[5:4]});
            chk(rd_cnt == 3 && rd_log[0] == a && rd_log[1] == a + 8 && rd_log[2] == a + 12,
                "R2 read order", {rd_log[1], rd_log[2]}, {a + 32'd8, a + 32'd12});
            chk(wb_cnt == 1 && wb_log[0] == a + 4 && mem[a[7:2]+1] == (c & 32'h7FFF_FFFF),
                "R4 status write-back", {wb_log[0], mem[a[7:2]+1]}, {a + 32'd4, c & 32'h7FFF_FFFF});
            chk({8'(bd_cnt), 8'(pkt_cnt), 8'(er_cnt), 8'(cs_cnt)} ==
                {8'(i[6]), 8'(i[7] & lifm), 8'd0, 8'(csr)}, "R5 event pulses",
                {8'(bd_cnt), 8'(pkt_cnt), 8'(er_cnt), 8'(cs_cnt)},
                {8'(i[6]), 8'(i[7] & lifm), 8'd0, 8'(csr)});
        end

        // R6 chain ended by zero pointer
        put_desc(32'h10, 32'h8001_0010, 32'h200, 32'h30);
        put_desc(32'h30, 32'h8001_0020, 32'h300, 32'h50);
        put_desc(32'h50, 32'h8007_0030, 32'h400, 32'h0);
        base_addr = 32'h10; clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(cmd_cnt == 3 && cur_log[0] == 32'h10 && cur_log[1] == 32'h30 && cur_log[2] == 32'h50,
            "R6 chain by pointer", {32'(cmd_cnt), cur_log[2]}, {32'd3, 32'h50});
        chk(wb_log[1] == 32'h34 && wb_log[2] == 32'h54 && bd_cnt == 3 && pkt_cnt == 1,
            "R6 chain write-backs and events", {wb_log[2], 32'(bd_cnt)}, {32'h54, 32'd3});

        // R6 chain ended by end flag despite nonzero pointer
        put_desc(32'h10, 32'h8000_0010, 32'h200, 32'h30);
        put_desc(32'h30, 32'h8008_0020, 32'h300, 32'h50);
        clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(cmd_cnt == 2 && cur_addr == 32'h30, "R6 end flag stops chain",
            {32'(cmd_cnt), cur_addr}, {32'd2, 32'h30});

        // R7 unowned without polling
        put_desc(32'h20, 32'h0008_0010, 32'h200, 0);
        base_addr = 32'h20; clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(er_cnt == 1 && cs_cnt == 1 && cmd_cnt == 0 && wb_cnt == 0 && !busy,
            "R7 unowned fault", {8'(er_cnt), 8'(cs_cnt), 8'(cmd_cnt)}, {8'd1, 8'd1, 8'd0});

        // R8 polling until ownership appears
        clr_logs();
        eng_write(3'b111);
        repeat (20) @(negedge clk);
        chk(busy && cmd_cnt == 0 && er_cnt == 0 && rd_cnt > 3, "R8 polling waits",
            {busy, 32'(cmd_cnt), 32'(rd_cnt)}, {1'b1, 32'd0, 32'd4});
        mem[8] = 32'h8008_0010;
        wait_idle();
        chk(cmd_cnt == 1 && er_cnt == 0 && cap_len == 9'h10, "R8 proceeds once owned",
            {32'(cmd_cnt), 32'(er_cnt)}, {32'd1, 32'd0});

        // R9 length limits
        put_desc(32'h20, 32'h8008_0100, 32'h200, 0);
        clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(cmd_cnt == 1 && cap_len == 9'd256 && er_cnt == 0, "R9 length 256 accepted",
            {32'(cmd_cnt), 23'd0, cap_len}, {32'd1, 32'd256});
        put_desc(32'h20, 32'h8008_0101, 32'h200, 0);
        clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(cmd_cnt == 0 && er_cnt == 1 && cs_cnt == 1, "R9 length 257 faults",
            {32'(cmd_cnt), 32'(er_cnt)}, {32'd0, 32'd1});

        // R10 read error on buffer word
        put_desc(32'h20, 32'h8008_0010, 32'h200, 0);
        err_addr = 32'h28; clr_logs();
        eng_write(3'b101);
        wait_idle();
        chk(cmd_cnt == 0 && er_cnt == 1 && cs_cnt == 1 && rd_cnt == 2, "R10 read error",
            {32'(cmd_cnt), 32'(rd_cnt)}, {32'd0, 32'd2});
        err_addr = 32'hFFFF_FFFF;

        // R11 stop during transfer
        xfer_lat = 50; clr_logs();
        put_desc(32'h20, 32'hC009_0010, 32'h200, 0);
        eng_write(3'b101);
        while (!cmd_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        eng_write(3'b000);
        repeat (60) @(negedge clk);
        chk(!busy && !cmd_valid && wb_cnt == 0 && bd_cnt == 0 && pkt_cnt == 0 && cs_cnt == 0,
            "R11 stop mid-transfer", {busy, 32'(wb_cnt), 32'(bd_cnt)}, 0);
        xfer_lat = 3;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule